// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command and address lines of an SDRAM module from reset until the memory may be used. It first keeps the bus deselected for a long settling pause. It then closes every bank with a precharge-all command and issues a fixed number of auto-refresh commands, spaced so that no bank-cycle window is violated. Last, it writes the mode register with the read latency, burst ordering, burst length and write-burst policy. When the recovery time after that write has run out, it raises a done flag, and the access controller takes over the bus.

The pause length, the refresh count, the three spacing windows and every mode field are parameters. Any timing value given in nanoseconds is turned into clocks by rounding up, and the integrator supplies the result in clocks. With the defaults, a 15 ns clock gives a 13 334-clock pause, two clocks after precharge, six clocks between refreshes and two clocks after the mode write. A synchronous reset at any moment restarts the whole sequence from the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: The 4-bit command is written as {cs_n, ras_n, cas_n, we_n}. While reset is asserted, and for PAUSE_CYC clocks after it is released (cycles 0 to PAUSE_CYC-1), the command is deselect 1111, addr is 0 and init_done is 0. No command cycle (cs_n low) occurs before cycle PAUSE_CYC.
- R2: The first command cycle is precharge-all (0010), issued at cycle PAUSE_CYC with addr bit 10 set and every other addr bit clear.
- R3: The first auto-refresh (0001) comes exactly T_RP clocks after the precharge, and the bus is deselected in between.
- R4: Exactly REFRESH_N auto-refresh commands are issued, each T_RC clocks after the one before, with deselect cycles in between.
- R5: The mode register write (0000) comes T_RC clocks after the last refresh, with ba = 0. Its address word holds the burst length code in bits [2:0] (1→0, 2→1, 4→2, 8→3), the burst order in bit 3 (1 = interleaved), the CAS latency in bits [6:4] and the write policy in bit 9 (1 = single-word writes). All other bits are 0.
- R6: init_done rises exactly T_MRD clocks after the mode register write. It then stays high, and the bus stays deselected.
- R7: cke is held at 1 in every cycle.
- R8: A full sequence contains exactly REFRESH_N+2 command cycles.
- R9: Asserting reset at any point, including after done, clears init_done in the next cycle and restarts the sequence from cycle 0.
- R10: With the default parameters (CAS latency 2, burst length 2, sequential order, burst writes), the mode word is 0x021.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory, always high |
| cs_n | output | 1 | Chip select, low only on command cycles |
| ras_n | output | 1 | Row strobe, part of the command code |
| cas_n | output | 1 | Column strobe, part of the command code |
| we_n | output | 1 | Write enable, part of the command code |
| addr | output | ADDR_W | Address lines: auto-precharge bit on precharge, mode word on mode write |
| ba | output | BA_W | Bank select, zero throughout |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Every result is due at a fixed cycle, counted from the first clock after reset is released. The precharge is due at cycle PAUSE_CYC. Refresh k is due at PAUSE_CYC+T_RP+k·T_RC. The mode write is due T_RC after the last refresh, and done is due T_MRD after the mode write. Because the outputs are decoded straight from the registered state, each command appears on the bus in the same cycle the state is entered. The bench keeps a cycle counter that clears with reset and samples every output on the falling edge at exactly those indices, including the cycle just before each event, which must still be idle. A monitor also counts every command cycle and measures the refresh spacing, so an extra or shifted command anywhere in the run is caught.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdram_cmd_t;

    localparam sdram_cmd_t CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdram_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdram_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam int MODE_W = 16;

    function automatic logic [2:0] burst_code(input int unsigned len);
        case (len)
            1:       burst_code = 3'd0;
            2:       burst_code = 3'd1;
            4:       burst_code = 3'd2;
            8:       burst_code = 3'd3;
            default: burst_code = 3'd7;
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] mode_word(input int unsigned cas_lat,
                                                    input int unsigned burst_len,
                                                    input bit interleave,
                                                    input bit single_write);
        logic [MODE_W-1:0] w;
        w      = '0;
        w[2:0] = burst_code(burst_len);
        w[3]   = interleave;
        w[6:4] = 3'(cas_lat);
        w[9]   = single_write;
        return w;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned RST_VAL = 13333
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= CNT_W'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: between loads the window shrinks by exactly one per clock
    p_timer_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R4: a loaded window is honoured before expiry
    p_timer_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned REFRESH_N = 8,
    parameter int unsigned T_RP      = 2,
    parameter int unsigned T_RC      = 6,
    parameter int unsigned T_MRD     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output init_state_e      state
);
    localparam int unsigned REF_W = $clog2(REFRESH_N + 1);

    init_state_e      nxt;
    logic [REF_W-1:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PAUSE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)                 ref_cnt <= '0;
        else if (state == ST_REF) ref_cnt <= ref_cnt + 1'b1;
    end

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_PAUSE:    if (tmr_zero) nxt = ST_PRE;
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 2);
                nxt      = ST_WAIT_RP;
            end
            ST_WAIT_RP:  if (tmr_zero) nxt = ST_REF;
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RC - 2);
                nxt      = ST_WAIT_RC;
            end
            ST_WAIT_RC: begin
                if (tmr_zero)
                    nxt = (ref_cnt == REF_W'(REFRESH_N)) ? ST_MRS : ST_REF;
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 2);
                nxt      = ST_WAIT_MRD;
            end
            ST_WAIT_MRD: if (tmr_zero) nxt = ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            default:     nxt = ST_PAUSE;
        endcase
    end

    // R4: refresh count never exceeds its target
    p_ref_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= REF_W'(REFRESH_N));

    // R5: mode write only after every refresh has gone out
    p_mrs_after_refs_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MRS) |-> (ref_cnt == REF_W'(REFRESH_N)));

    // R6: completion is sticky until reset
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_DONE));

endmodule

// File: rtl/sdram_init_cmd.sv
module sdram_init_cmd
    import sdram_init_pkg::*;
#(
    parameter int unsigned      ADDR_W = 14,
    parameter int unsigned      AP_BIT = 10,
    parameter logic [MODE_W-1:0] MODE  = '0
) (
    input  init_state_e       state,
    output sdram_cmd_t        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    always_comb begin
        cmd  = CMD_IDLE;
        addr = '0;
        done = 1'b0;
        case (state)
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE[ADDR_W-1:0];
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 13334,
    parameter int unsigned REFRESH_N    = 8,
    parameter int unsigned T_RP         = 2,
    parameter int unsigned T_RC         = 6,
    parameter int unsigned T_MRD        = 2,
    parameter int unsigned CAS_LAT      = 2,
    parameter int unsigned BURST_LEN    = 2,
    parameter bit          INTERLEAVE   = 1'b0,
    parameter bit          SINGLE_WRITE = 1'b0,
    parameter int unsigned ADDR_W       = 14,
    parameter int unsigned BA_W         = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);
    localparam int unsigned AP_BIT = 10;
    localparam int unsigned CNT_W  = $clog2(max4(PAUSE_CYC, T_RP, T_RC, T_MRD) + 1);
    localparam logic [MODE_W-1:0] MODE_VAL =
        mode_word(CAS_LAT, BURST_LEN, INTERLEAVE, SINGLE_WRITE);

    init_state_e      state;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    sdram_cmd_t       cmd;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PAUSE_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdram_init_fsm #(
        .CNT_W     (CNT_W),
        .REFRESH_N (REFRESH_N),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state)
    );

    sdram_init_cmd #(
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT),
        .MODE   (MODE_VAL)
    ) cmd_i (
        .state (state),
        .cmd   (cmd),
        .addr  (addr),
        .done  (init_done)
    );

    assign cke   = 1'b1;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign ba    = '0;

    // R2: every precharge closes all banks
    p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[AP_BIT]);

    // R6: the bus is released once done
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        init_done |-> cs_n);

    // R3: no two command cycles back to back
    p_cmd_gap_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> cs_n);

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

    localparam int P   = 13334;
    localparam int RP  = 2;
    localparam int RC  = 6;
    localparam int N   = 8;
    localparam int MRD = 2;
    localparam int TREF0 = P + RP;
    localparam int TMRS  = P + RP + N * RC;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [13:0] addr;
    logic [1:0]  ba;

    sdram_init_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct packed {
        logic [31:0] at;
        logic [3:0]  cmd;
        logic [13:0] addr;
        logic        done;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'(0),                  4'hF,    14'h000, 1'b0, 8'd1},   // R1 idle at start
        '{32'(P / 2),              4'hF,    14'h000, 1'b0, 8'd1},   // R1 mid pause
        '{32'(P - 1),              4'hF,    14'h000, 1'b0, 8'd1},   // R1 last pause cycle
        '{32'(P),                  4'b0010, 14'h400, 1'b0, 8'd2},   // R2 precharge-all
        '{32'(P + 1),              4'hF,    14'h000, 1'b0, 8'd3},   // R3 gap
        '{32'(TREF0),              4'b0001, 14'h000, 1'b0, 8'd3},   // R3 first refresh
        '{32'(TREF0 + 1),          4'hF,    14'h000, 1'b0, 8'd4},   // R4 gap
        '{32'(TREF0 + RC - 1),     4'hF,    14'h000, 1'b0, 8'd4},   // R4 gap end
        '{32'(TREF0 + RC),         4'b0001, 14'h000, 1'b0, 8'd4},   // R4 second refresh
        '{32'(TREF0 + (N-1) * RC), 4'b0001, 14'h000, 1'b0, 8'd4},   // R4 last refresh
        '{32'(TMRS - 1),           4'hF,    14'h000, 1'b0, 8'd5},   // R5 idle before
        '{32'(TMRS),               4'b0000, 14'h021, 1'b0, 8'd10},  // R5 R10 mode word
        '{32'(TMRS + MRD - 1),     4'hF,    14'h000, 1'b0, 8'd6},   // R6 not yet done
        '{32'(TMRS + MRD),         4'hF,    14'h000, 1'b1, 8'd6}    // R6 done
    };

    int n_cmd, n_ref, first_cmd, last_ref, bad_gap, cke_low;

    always @(negedge clk) begin
        if (rst) begin
            n_cmd = 0; n_ref = 0; first_cmd = -1; last_ref = 0; bad_gap = 0; cke_low = 0;
        end else begin
            if (!cke) cke_low++;
            if (!cs_n) begin
                if (n_cmd == 0) first_cmd = cyc;
                n_cmd++;
            end
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) begin
                if (n_ref > 0 && (cyc - last_ref) != RC) bad_gap++;
                last_ref = cyc;
                n_ref++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic walk_table();
        for (int i = 0; i < NV; i++) begin
            int act, exp;
            while (cyc < int'(VEC[i].at)) @(negedge clk);
            act = {13'd0, cs_n, ras_n, cas_n, we_n, addr, init_done};
            exp = {13'd0, VEC[i].cmd, VEC[i].addr, VEC[i].done};
            check(act == exp, $sformatf("R%0d at cycle %0d", VEC[i].req, VEC[i].at), act, exp);
        end
    endtask

    task automatic run_totals();
        check(n_cmd == N + 2, "R8 command count", n_cmd, N + 2);
        check(n_ref == N, "R4 refresh count", n_ref, N);
        check(bad_gap == 0, "R4 refresh spacing", bad_gap, 0);
        check(first_cmd == P, "R1 first command cycle", first_cmd, P);
        check(cke_low == 0, "R7 cke held high", cke_low, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({cs_n, ras_n, cas_n, we_n, init_done} == 5'b11110, "R1 reset state",
              {cs_n, ras_n, cas_n, we_n, init_done}, 5'b11110);
        check(cke == 1'b1, "R7 cke during reset", cke, 1);
        rst = 1'b0;
        walk_table();
        repeat (50) @(negedge clk);
        check(init_done == 1'b1 && cs_n == 1'b1, "R6 done sticky", {init_done, cs_n}, 2'b11);
        run_totals();

        // R9 reset after done
        rst = 1'b1;
        @(negedge clk);
        check(init_done == 1'b0, "R9 done cleared by reset", init_done, 0);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset in the middle of the refresh phase
        while (cyc < TREF0 + 3 * RC + 1) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check({cs_n, init_done} == 2'b10, "R9 idle after mid reset", {cs_n, init_done}, 2'b10);
        rst = 1'b0;
        walk_table();
        run_totals();
        summary();
    end

endmodule